// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block issues data memory addresses for indirect accesses. It holds four index pointers, four signed modify registers, and one length register and one base register for each pointer. An access names one pointer and one modify register. The selected pointer's current value is the address for that cycle. At the same clock edge the pointer advances by the selected modify value, so the access costs no extra cycle.

When a pointer's length is zero, the update is a plain addition that wraps at the address width. When the length is non-zero, the pointer stays inside the circular window [base, base+length-1], for steps in either direction. A single register-write port loads any index, modify, length or base register. A processor uses two of these units for dual operand fetches; this project delivers one of them.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset every index, modify, length and base register is zero, so an access to any pointer presents address 0.
- R2: `addr_o` shows the current value of the pointer selected by `acc_ptr` in the same cycle, with no register stage. The value shown is the value before that access's update.
- R3: With the selected pointer's length at zero, an access sets the pointer to pointer + modify, modulo 2^14, at the next clock edge. The modify value is signed two's complement, 14 bits wide.
- R4: With a non-zero length L and base B, a forward step that reaches or passes B+L lands at (pointer + modify − L).
- R5: With a non-zero length, a backward step that falls below B lands at (pointer + modify + L).
- R6: `acc_mod` selects any one of the four modify registers for each access. `wr_field` selects the register type being written: 0 = index, 1 = modify, 2 = length, 3 = base. `wr_num` selects which of the four registers of that type is written.
- R7: When an index write and an access hit the same pointer in one cycle, the written value wins. The address shown in that cycle is still the old pointer value.
- R8: A pointer changes only when it is accessed or written. An access to one pointer leaves the other pointers unchanged.
- R9: A step whose magnitude equals a non-zero length leaves the pointer unchanged. Step magnitudes are assumed not to exceed the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Indirect access in this cycle |
| acc_ptr | input | 2 | Pointer selected for the access |
| acc_mod | input | 2 | Modify register selected for the access |
| wr_en | input | 1 | Register write in this cycle |
| wr_field | input | 2 | Register type: 0 index, 1 modify, 2 length, 3 base |
| wr_num | input | 2 | Register number within the type |
| wr_data | input | 14 | Write data |
| addr_o | output | 14 | Address: current value of the selected pointer |

## Verification
The address is combinational, so it is due in the same cycle as its access. The bench drives each step just after a falling edge and samples `addr_o` one time unit later, before the next rising edge. The pointer update and any register write take effect at that rising edge. Their effect is therefore checked through the address of a later access, sampled in the same place in the next step. A write and an access that hit the same pointer in one step are checked in two parts: the old address in that step, and the written value in the step after.

// File: rtl/cdag_pkg.sv
package cdag_pkg;
   typedef enum logic [1:0] {
      FLD_INDEX  = 2'd0,
      FLD_MODIFY = 2'd1,
      FLD_LENGTH = 2'd2,
      FLD_BASE   = 2'd3
   } wr_field_e;
endpackage

// File: rtl/cdag_step.sv
module cdag_step #(
   parameter int AW      = 14,
   parameter bit CIRC_EN = 1'b1
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] step,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] len,
   output logic [AW-1:0] nxt
);
   localparam int SW = AW + 2;

   logic signed [SW-1:0] sum_s;
   logic signed [SW-1:0] step_s;
   assign step_s = {{2{step[AW-1]}}, step};
   assign sum_s  = $signed({2'b00, cur}) + step_s;

   generate
      if (CIRC_EN) begin : g_circ
         logic signed [SW-1:0] lo_s, hi_s, len_s;
         assign lo_s  = $signed({2'b00, base});
         assign len_s = $signed({2'b00, len});
         assign hi_s  = lo_s + len_s;
         always_comb begin
            nxt = sum_s[AW-1:0];
            if (len != '0) begin
               if (!step[AW-1] && (sum_s >= hi_s))
                  nxt = AW'(sum_s - len_s);
               else if (step[AW-1] && (sum_s < lo_s))
                  nxt = AW'(sum_s + len_s);
            end
         end
      end else begin : g_lin
         logic unused_ok;
         assign unused_ok = ^{base, len};
         assign nxt = sum_s[AW-1:0];
      end
   endgenerate
endmodule

// File: rtl/cdag_mod_file.sv
module cdag_mod_file #(
   parameter int AW   = 14,
   parameter int NMOD = 4,
   localparam int MSW = $clog2(NMOD)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [MSW-1:0]           wnum,
   input  logic [AW-1:0]            wdata,
   input  logic [MSW-1:0]           rsel,
   output logic [AW-1:0]            rdata,
   output logic [NMOD-1:0][AW-1:0]  mods
);
   generate
      for (genvar m = 0; m < NMOD; m++) begin : g_mod
         always_ff @(posedge clk) begin
            if (!rst_n)
               mods[m] <= '0;
            else if (we && (wnum == MSW'(m)))
               mods[m] <= wdata;
         end
      end
   endgenerate
   assign rdata = mods[rsel];
endmodule

// File: rtl/cdag_ptr_bank.sv
module cdag_ptr_bank
   import cdag_pkg::*;
#(
   parameter int AW   = 14,
   parameter int NPTR = 4,
   localparam int PSW = $clog2(NPTR)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [1:0]               wr_field,
   input  logic [PSW-1:0]           wr_num,
   input  logic [AW-1:0]            wr_data,
   input  logic                     upd_en,
   input  logic [PSW-1:0]           upd_ptr,
   input  logic [AW-1:0]            upd_val,
   output logic [NPTR-1:0][AW-1:0]  idx,
   output logic [NPTR-1:0][AW-1:0]  len,
   output logic [NPTR-1:0][AW-1:0]  base
);
   wr_field_e fld;
   assign fld = wr_field_e'(wr_field);

   generate
      for (genvar p = 0; p < NPTR; p++) begin : g_ptr
         logic hit_w, hit_u;
         assign hit_w = wr_en && (wr_num == PSW'(p));
         assign hit_u = upd_en && (upd_ptr == PSW'(p));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               idx[p]  <= '0;
               len[p]  <= '0;
               base[p] <= '0;
            end else begin
               // an index write outranks the post-modify of the same pointer
               if (hit_w && (fld == FLD_INDEX))
                  idx[p] <= wr_data;
               else if (hit_u)
                  idx[p] <= upd_val;
               if (hit_w && (fld == FLD_LENGTH))
                  len[p] <= wr_data;
               if (hit_w && (fld == FLD_BASE))
                  base[p] <= wr_data;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
   import cdag_pkg::*;
#(
   parameter int AW      = 14,
   parameter int NPTR    = 4,
   parameter int NMOD    = 4,
   parameter bit CIRC_EN = 1'b1,
   localparam int PSW    = $clog2(NPTR),
   localparam int MSW    = $clog2(NMOD)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           acc_en,
   input  logic [PSW-1:0] acc_ptr,
   input  logic [MSW-1:0] acc_mod,
   input  logic           wr_en,
   input  logic [1:0]     wr_field,
   input  logic [PSW-1:0] wr_num,
   input  logic [AW-1:0]  wr_data,
   output logic [AW-1:0]  addr_o
);
   initial begin
      if (AW < 4 || AW > 30)
         $error("circ_addr_gen: AW out of range");
      if (NPTR < 2 || (NPTR & (NPTR - 1)) != 0)
         $error("circ_addr_gen: NPTR must be a power of two");
      if (NMOD < 2 || (NMOD & (NMOD - 1)) != 0)
         $error("circ_addr_gen: NMOD must be a power of two");
      if (MSW > PSW)
         $error("circ_addr_gen: wr_num too narrow to address modify registers");
   end

   logic [NPTR-1:0][AW-1:0] idx_q, len_q, base_q;
   logic [NMOD-1:0][AW-1:0] mod_q;
   logic [AW-1:0]           step_v, nxt_v;
   logic                    mod_we;

   assign mod_we = wr_en && (wr_field_e'(wr_field) == FLD_MODIFY);

   cdag_mod_file #(.AW(AW), .NMOD(NMOD)) u_mods (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mod_we),
      .wnum  (MSW'(wr_num)),
      .wdata (wr_data),
      .rsel  (acc_mod),
      .rdata (step_v),
      .mods  (mod_q)
   );

   cdag_step #(.AW(AW), .CIRC_EN(CIRC_EN)) u_step (
      .cur  (idx_q[acc_ptr]),
      .step (step_v),
      .base (base_q[acc_ptr]),
      .len  (len_q[acc_ptr]),
      .nxt  (nxt_v)
   );

   cdag_ptr_bank #(.AW(AW), .NPTR(NPTR)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_field (wr_field),
      .wr_num   (wr_num),
      .wr_data  (wr_data),
      .upd_en   (acc_en),
      .upd_ptr  (acc_ptr),
      .upd_val  (nxt_v),
      .idx      (idx_q),
      .len      (len_q),
      .base     (base_q)
   );

   assign addr_o = idx_q[acc_ptr];
endmodule

// File: rtl/circ_addr_gen_chk.sv
module circ_addr_gen_chk #(
   parameter int AW   = 14,
   parameter int NPTR = 4,
   parameter int NMOD = 4,
   localparam int PSW = $clog2(NPTR),
   localparam int MSW = $clog2(NMOD)
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    acc_en,
   input logic [PSW-1:0]          acc_ptr,
   input logic [MSW-1:0]          acc_mod,
   input logic                    wr_en,
   input logic [1:0]              wr_field,
   input logic [PSW-1:0]          wr_num,
   input logic [AW-1:0]           wr_data,
   input logic [NPTR-1:0][AW-1:0] idx,
   input logic [NPTR-1:0][AW-1:0] len,
   input logic [NPTR-1:0][AW-1:0] base,
   input logic [NMOD-1:0][AW-1:0] mods
);
   logic [AW-1:0] c_idx, c_len, c_base, c_mod, c_mag;
   logic [AW:0]   c_hi;
   logic          in_win, mag_ok;
   assign c_idx  = idx[acc_ptr];
   assign c_len  = len[acc_ptr];
   assign c_base = base[acc_ptr];
   assign c_mod  = mods[acc_mod];
   assign c_mag  = c_mod[AW-1] ? AW'(-c_mod) : c_mod;
   assign c_hi   = {1'b0, c_base} + {1'b0, c_len};
   assign in_win = ({1'b0, c_idx} >= {1'b0, c_base}) && ({1'b0, c_idx} < c_hi);
   assign mag_ok = (c_mag <= c_len) && !c_hi[AW];

   // R3: linear post-modify when length is zero
   a_r3_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !wr_en && c_len == '0)
      |=> idx[$past(acc_ptr)] == $past(AW'(c_idx + c_mod)));

   // R4 / R5: pointer stays inside its window
   a_r4_r5_stay_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !wr_en && c_len != '0 && in_win && mag_ok)
      |=> ({1'b0, idx[$past(acc_ptr)]} >= {1'b0, $past(c_base)}) &&
          ({1'b0, idx[$past(acc_ptr)]} < $past(c_hi)));

   // R7: index write wins over an access to the same pointer
   a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_field == 2'd0)
      |=> idx[$past(wr_num)] == $past(wr_data));

   // R8: no access and no write leaves all pointers alone
   a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_en && !wr_en) |=> $stable(idx));

   // R9: full-length step returns to the same pointer
   a_r9_full_turn: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && !wr_en && c_len != '0 && in_win && !c_hi[AW] && c_mag == c_len)
      |=> idx[$past(acc_ptr)] == $past(c_idx));
endmodule

bind circ_addr_gen circ_addr_gen_chk #(.AW(AW), .NPTR(NPTR), .NMOD(NMOD)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .acc_en   (acc_en),
   .acc_ptr  (acc_ptr),
   .acc_mod  (acc_mod),
   .wr_en    (wr_en),
   .wr_field (wr_field),
   .wr_num   (wr_num),
   .wr_data  (wr_data),
   .idx      (idx_q),
   .len      (len_q),
   .base     (base_q),
   .mods     (mod_q)
);

// File: tb/tb_circ_addr_gen.sv
module tb_circ_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0;
   logic [1:0]  acc_ptr = '0, acc_mod = '0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_field = '0, wr_num = '0;
   logic [13:0] wr_data = '0;
   logic [13:0] addr_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   circ_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_ptr(acc_ptr),
      .acc_mod(acc_mod), .wr_en(wr_en), .wr_field(wr_field),
      .wr_num(wr_num), .wr_data(wr_data), .addr_o(addr_o)
   );

   // entry: {is_wr, field, ptr/num, modsel, data[13:0], expected addr[13:0]}
   localparam int NV = 18;
   localparam logic [34:0] TBL [NV] = '{
      {1'b1, 2'd1, 2'd0, 2'd0, 14'd3,      14'd0},     // modify0 = +3
      {1'b1, 2'd1, 2'd1, 2'd0, 14'h3FFE,   14'd0},     // modify1 = -2
      {1'b1, 2'd3, 2'd0, 2'd0, 14'd100,    14'd0},     // base0 = 100
      {1'b1, 2'd2, 2'd0, 2'd0, 14'd5,      14'd0},     // length0 = 5
      {1'b1, 2'd0, 2'd0, 2'd0, 14'd100,    14'd0},     // index0 = 100
      {1'b0, 2'd0, 2'd0, 2'd0, 14'd0,      14'd100},   // R2 -> 103
      {1'b0, 2'd0, 2'd0, 2'd0, 14'd0,      14'd103},   // R4 wrap -> 101
      {1'b0, 2'd0, 2'd0, 2'd0, 14'd0,      14'd101},   // -> 104
      {1'b0, 2'd0, 2'd0, 2'd1, 14'd0,      14'd104},   // R6 m1 -> 102
      {1'b0, 2'd0, 2'd0, 2'd1, 14'd0,      14'd102},   // -> 100
      {1'b0, 2'd0, 2'd0, 2'd1, 14'd0,      14'd100},   // R5 wrap -> 103
      {1'b0, 2'd0, 2'd0, 2'd0, 14'd0,      14'd103},   // R4 -> 101
      {1'b1, 2'd0, 2'd1, 2'd0, 14'd16382,  14'd0},     // index1 = 16382
      {1'b0, 2'd0, 2'd1, 2'd0, 14'd0,      14'd16382}, // R3 -> 1
      {1'b0, 2'd0, 2'd1, 2'd1, 14'd0,      14'd1},     // R3 -> 16383
      {1'b0, 2'd0, 2'd1, 2'd0, 14'd0,      14'd16383}, // R3 -> 2
      {1'b0, 2'd0, 2'd0, 2'd2, 14'd0,      14'd101},   // R6 m2 = 0 -> 101
      {1'b0, 2'd0, 2'd0, 2'd0, 14'd0,      14'd101}    // R8 p0 unaffected by p1 -> 104
   };

   task automatic check(input string req, input logic [13:0] exp);
      n_cmp++;
      if (addr_o !== exp) begin
         n_bad++;
         $display("FAIL %s: addr_o actual=%0d expected=%0d", req, addr_o, exp);
      end
   endtask

   // one step: drive after falling edge, sample before rising edge
   task automatic step(input bit acc, input logic [1:0] p, input logic [1:0] m,
                       input bit wr, input logic [1:0] f, input logic [1:0] n,
                       input logic [13:0] d, input bit chk, input string req,
                       input logic [13:0] exp);
      @(negedge clk);
      acc_en = acc; acc_ptr = p; acc_mod = m;
      wr_en = wr; wr_field = f; wr_num = n; wr_data = d;
      #1;
      if (chk) check(req, exp);
      @(posedge clk);
   endtask

   initial begin
      fork
         begin
            repeat (5000) @(posedge clk);
            if (!done) begin
               n_cmp++; n_bad++;
               $display("FAIL watchdog: actual=timeout expected=finish");
               $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
               $finish;
            end
         end
      join_none

      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R1: every pointer reads zero after reset
      for (int p = 0; p < 4; p++) begin
         @(negedge clk);
         acc_ptr = 2'(p); acc_en = 1'b0;
         #1 check("R1", 14'd0);
      end

      // table walk
      for (int i = 0; i < NV; i++) begin
         logic [34:0] e;
         e = TBL[i];
         step(!e[34], e[31:30], e[29:28], e[34], e[33:32], e[31:30],
              e[27:14], !e[34], "R2-R6 table", e[13:0]);
      end

      // R9: modify3 = +5 equals length0; pointer 0 is 104
      step(1'b0, 2'd0, 2'd0, 1'b1, 2'd1, 2'd3, 14'd5, 1'b0, "", 14'd0);
      step(1'b1, 2'd0, 2'd3, 1'b0, 2'd0, 2'd0, 14'd0, 1'b1, "R9", 14'd104);
      step(1'b1, 2'd0, 2'd3, 1'b0, 2'd0, 2'd0, 14'd0, 1'b1, "R9", 14'd104);

      // R7: same-cycle access and index write on pointer 2
      step(1'b1, 2'd2, 2'd0, 1'b1, 2'd0, 2'd2, 14'd50, 1'b1, "R7 old addr", 14'd0);
      step(1'b1, 2'd2, 2'd2, 1'b0, 2'd0, 2'd0, 14'd0, 1'b1, "R7 write wins", 14'd50);

      // R8: pointer 1 left at 2 by the table, pointer 3 never touched
      step(1'b0, 2'd1, 2'd0, 1'b0, 2'd0, 2'd0, 14'd0, 1'b1, "R8 p1", 14'd2);
      step(1'b0, 2'd3, 2'd0, 1'b0, 2'd0, 2'd0, 14'd0, 1'b1, "R8 p3", 14'd0);
      step(1'b0, 2'd2, 2'd0, 1'b0, 2'd0, 2'd0, 14'd0, 1'b1, "R8 p2 idle", 14'd50);

      @(negedge clk);
      acc_en = 1'b0; wr_en = 1'b0;
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule